// File: doc/BRIEF.md
# Packed Byte SAD Video Unit

This datapath operates on 32-bit words that hold four unsigned 8-bit pixels. It is aimed at motion estimation, block matching and image filtering kernels. One opcode selects the operation for each issued item.

The first operation is a four-lane sum of absolute differences. It is added to a 32-bit accumulator input, so a 4x4 block cost builds up over four chained issues. The second is a per-byte average of two pixel words, which either rounds halves up or truncates. The last two are funnel extractions. They take a 32-bit window from the 64-bit concatenation of the two operands, at any bit offset or at a byte offset.

Items enter with a valid strobe. Every opcode leaves the block exactly two cycles later, with a matching valid strobe and a registered result.

Top module: `pix_video_unit`

## Requirements
- R1: While `rst` is high, `out_valid` and `out_result` are cleared to 0 at the next clock edge.
- R2: An item accepted with `in_valid` high at clock edge k appears with `out_valid` high right after edge k+1, for every opcode. Cycles with `in_valid` low produce no output.
- R3: Opcode 0 (SAD) returns `in_acc` plus the sum, over the four bytes (byte i = bits [8i+7:8i]), of |a_i - b_i|. The sum is taken modulo 2^32, with wrap-around and no saturation. Four chained issues therefore form a 4x4 block cost.
- R4: Opcode 1 (AVG) with `in_round` = 1 returns, for each byte i, (a_i + b_i + 1) >> 1. No carry passes between bytes.
- R5: Opcode 1 (AVG) with `in_round` = 0 returns, for each byte i, (a_i + b_i) >> 1.
- R6: Opcode 2 (bit align) returns bits [s+31:s] of the 64-bit value {in_a, in_b}, where s = `in_shift` (0 to 31). `in_a` is the upper word.
- R7: Opcode 3 (byte align) returns bits [8s+31:8s] of {in_a, in_b}, where s = `in_shift[1:0]`. Bits [4:2] of `in_shift` are ignored.
- R8: On cycles where `out_valid` is low, `out_result` keeps its last value.
- R9: `in_round` affects only AVG. `in_acc` affects only SAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Item valid strobe |
| in_op | input | 2 | Opcode: 0 SAD, 1 AVG, 2 bit align, 3 byte align |
| in_a | input | 32 | Pixel word A, or upper word for the align opcodes |
| in_b | input | 32 | Pixel word B, or lower word for the align opcodes |
| in_acc | input | 32 | Accumulator added to the SAD |
| in_round | input | 1 | 1 rounds averages half up, 0 truncates them |
| in_shift | input | 5 | Extraction offset, in bits or in bytes |
| out_valid | output | 1 | Result valid strobe |
| out_result | output | 32 | Registered result |

## Verification
The data assertions assume that the operand, opcode and shift inputs are known (not X) whenever `in_valid` is high. They also assume those inputs may change freely between items, because the checks look back exactly two cycles to the accepted item. The stimulus drives every input on the falling edge and holds it for a full cycle. It sends items back to back and also with idle gaps. After reset it never leaves an input unknown, so every check two cycles later reads a defined item. The vectors include SAD cases with equal operands and with accumulator wrap-around, averages with all byte values at 0xFF, and shifts at 0, 31 and with the ignored high bits set in byte mode.

// File: rtl/pix_pkg.sv
package pix_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;
  localparam int SHW    = $clog2(WORD_W);
  localparam int BSW    = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_SAD      = 2'd0,
    OP_AVG      = 2'd1,
    OP_BITALIGN = 2'd2,
    OP_BYTALIGN = 2'd3
  } pix_op_e;
endpackage

// File: rtl/pix_lane_absdiff.sv
module pix_lane_absdiff #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] x,
  input  logic [LW-1:0] y,
  output logic [LW-1:0] d
);
  always_comb begin
    if (x >= y) d = x - y;
    else        d = y - x;
  end
endmodule

// File: rtl/pix_lane_avg.sv
module pix_lane_avg #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] x,
  input  logic [LW-1:0] y,
  input  logic          rnd,
  output logic [LW-1:0] m
);
  logic [LW:0] s;
  always_comb begin
    s = {1'b0, x} + {1'b0, y} + {{LW{1'b0}}, rnd};
    m = s[LW:1];
  end
endmodule

// File: rtl/pix_funnel_align.sv
module pix_funnel_align #(
  parameter int W   = 32,
  parameter int LW  = 8,
  parameter int SHW = 5,
  parameter int BSW = 2
) (
  input  logic [W-1:0]   hi,
  input  logic [W-1:0]   lo,
  input  logic [SHW-1:0] shift,
  input  logic           byte_mode,
  output logic [W-1:0]   win
);
  localparam int LWB = $clog2(LW);
  logic [2*W-1:0] cat;
  logic [SHW-1:0] amt;
  always_comb begin
    cat = {hi, lo};
    if (byte_mode) amt = SHW'(shift[BSW-1:0]) << LWB;
    else           amt = shift;
    win = W'(cat >> amt);
  end
endmodule

// File: rtl/pix_video_unit.sv
module pix_video_unit
  import pix_pkg::*;
#(
  parameter int NL  = LANES,
  parameter int LW  = LANE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           in_op,
  input  logic [NL*LW-1:0]     in_a,
  input  logic [NL*LW-1:0]     in_b,
  input  logic [NL*LW-1:0]     in_acc,
  input  logic                 in_round,
  input  logic [$clog2(NL*LW)-1:0] in_shift,
  output logic                 out_valid,
  output logic [NL*LW-1:0]     out_result
);
  localparam int W  = NL * LW;
  localparam int SW = $clog2(W);
  localparam int BW = $clog2(NL);

  pix_op_e         op_in;
  logic [W-1:0]    diff_c, avg_c, align_c;

  assign op_in = pix_op_e'(in_op);

  for (genvar i = 0; i < NL; i++) begin : g_lane
    pix_lane_absdiff #(.LW(LW)) u_abs (
      .x(in_a[i*LW +: LW]), .y(in_b[i*LW +: LW]), .d(diff_c[i*LW +: LW])
    );
    pix_lane_avg #(.LW(LW)) u_avg (
      .x(in_a[i*LW +: LW]), .y(in_b[i*LW +: LW]), .rnd(in_round),
      .m(avg_c[i*LW +: LW])
    );
  end

  pix_funnel_align #(.W(W), .LW(LW), .SHW(SW), .BSW(BW)) u_align (
    .hi(in_a), .lo(in_b), .shift(in_shift),
    .byte_mode(op_in == OP_BYTALIGN), .win(align_c)
  );

  // Stage 1: per-lane results, accumulator and opcode registered
  logic         s1_valid;
  pix_op_e      s1_op;
  logic [W-1:0] s1_acc, s1_diff, s1_avg, s1_align;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_SAD;
      s1_acc   <= '0;
      s1_diff  <= '0;
      s1_avg   <= '0;
      s1_align <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_op    <= op_in;
        s1_acc   <= in_acc;
        s1_diff  <= diff_c;
        s1_avg   <= avg_c;
        s1_align <= align_c;
      end
    end
  end

  // Stage 2: lane reduction plus accumulator, result select
  logic [W-1:0] sad_sum, sel;
  always_comb begin
    sad_sum = s1_acc;
    for (int i = 0; i < NL; i++)
      sad_sum = sad_sum + W'(s1_diff[i*LW +: LW]);
    case (s1_op)
      OP_SAD:  sel = sad_sum;
      OP_AVG:  sel = s1_avg;
      default: sel = s1_align;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_result <= sel;
    end
  end
endmodule

// File: rtl/pix_video_unit_chk.sv
module pix_video_unit_chk #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    in_op,
  input logic [W-1:0]  in_a,
  input logic [W-1:0]  in_b,
  input logic [W-1:0]  in_acc,
  input logic [SW-1:0] in_shift,
  input logic          out_valid,
  input logic [W-1:0]  out_result
);
  logic [1:0] vsh;
  always_ff @(posedge clk) begin
    if (rst) vsh <= '0;
    else     vsh <= {vsh[0], in_valid};
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_valid && out_result == '0));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vsh[1]);

  a_r3_equal_ops_give_acc: assert property (@(posedge clk) disable iff (rst)
    (vsh[1] && $past(in_op, 2) == 2'd0 && $past(in_a, 2) == $past(in_b, 2))
    |-> out_result == $past(in_acc, 2));

  a_r6_zero_shift_lower: assert property (@(posedge clk) disable iff (rst)
    (vsh[1] && $past(in_op, 2) == 2'd2 && $past(in_shift, 2) == '0)
    |-> out_result == $past(in_b, 2));

  a_r7_byte_zero_lower: assert property (@(posedge clk) disable iff (rst)
    (vsh[1] && $past(in_op, 2) == 2'd3 && ($past(in_shift, 2) & SW'(3)) == '0)
    |-> out_result == $past(in_b, 2));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_result));
endmodule

bind pix_video_unit pix_video_unit_chk #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
  .in_b(in_b), .in_acc(in_acc), .in_shift(in_shift),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/pix_video_unit_bench.sv
module pix_video_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic [31:0] in_a = '0, in_b = '0, in_acc = '0;
  logic        in_round = 1'b0;
  logic [4:0]  in_shift = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_exp = '0;

  always #4 clk = ~clk;

  pix_video_unit u_pix_video_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_a(in_a),
    .in_b(in_b), .in_acc(in_acc), .in_round(in_round), .in_shift(in_shift),
    .out_valid(out_valid), .out_result(out_result)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [31:0] acc, input logic rnd, input logic [4:0] sh);
    logic [31:0] r;
    logic [63:0] cat;
    int x, y, s;
    cat = {a, b};
    r = 0;
    case (op)
      2'd0: begin
        r = acc;
        for (int i = 0; i < 4; i++) begin
          x = int'(a[8*i +: 8]); y = int'(b[8*i +: 8]);
          r = r + 32'((x > y) ? x - y : y - x);
        end
      end
      2'd1: for (int i = 0; i < 4; i++) begin
        s = int'(a[8*i +: 8]) + int'(b[8*i +: 8]) + (rnd ? 1 : 0);
        r[8*i +: 8] = 8'(s / 2);
      end
      2'd2: r = cat[int'(sh) +: 32];
      default: r = cat[8*int'(sh[1:0]) +: 32];
    endcase
    return r;
  endfunction

  task automatic send(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
      input logic [31:0] acc, input logic rnd, input logic [4:0] sh, input string tag);
    exp_q.push_back(model(op, a, b, acc, rnd, sh));
    tag_q.push_back(tag);
    in_op = op; in_a = a; in_b = b; in_acc = acc; in_round = rnd; in_shift = sh;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Monitor: pop and compare each produced result
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected output actual %h expected none", out_result);
      end else begin
        last_exp = exp_q.pop_front();
        chk(tag_q.pop_front(), out_result, last_exp);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] chain;
    repeat (3) @(negedge clk);
    chk("R1 valid", {31'b0, out_valid}, 32'd0);
    chk("R1 result", out_result, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R2 explicit latency
    send(2'd0, 32'h10203040, 32'h01020304, 32'd5, 1'b0, 5'd0, "R3 sad basic");
    chk("R2 not yet", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    chk("R2 at two", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R2 single", {31'b0, out_valid}, 32'd0);

    // R3 SAD cases, back to back
    send(2'd0, 32'hFF00FF00, 32'h00FF00FF, 32'd0, 1'b1, 5'd7, "R3 max diff");
    send(2'd0, 32'h5A5A5A5A, 32'h5A5A5A5A, 32'hDEADBEEF, 1'b0, 5'd0, "R3 equal ops");
    send(2'd0, 32'h00000020, 32'h00000000, 32'hFFFFFFF0, 1'b0, 5'd0, "R3 wrap");
    // R3 4x4 chain via accumulator
    chain = 32'd0;
    for (int r = 0; r < 4; r++) begin
      logic [31:0] ra, rb;
      ra = 32'h11223344 + 32'(r * 32'h01030507);
      rb = 32'h44332211 ^ 32'(r * 32'h10101010);
      send(2'd0, ra, rb, chain, 1'b0, 5'd0, "R3 chain");
      chain = model(2'd0, ra, rb, chain, 1'b0, 5'd0);
    end
    repeat (3) @(negedge clk);
    chk("R3 chain total", out_result, chain);

    // R4 / R5 averages
    send(2'd1, 32'h01FF0380, 32'h02FF0481, 32'd99, 1'b1, 5'd0, "R4 round up");
    send(2'd1, 32'h01FF0380, 32'h02FF0481, 32'd99, 1'b0, 5'd0, "R5 truncate");
    send(2'd1, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'd0, 1'b1, 5'd0, "R4 no carry");
    send(2'd1, 32'h00010001, 32'h00000000, 32'd0, 1'b0, 5'd0, "R5 no carry");
    // R6 bit align
    send(2'd2, 32'hCAFEBABE, 32'h12345678, 32'd7, 1'b1, 5'd0, "R6 shift 0");
    send(2'd2, 32'hCAFEBABE, 32'h12345678, 32'd0, 1'b0, 5'd13, "R6 shift 13");
    send(2'd2, 32'hCAFEBABE, 32'h12345678, 32'd0, 1'b0, 5'd31, "R6 shift 31");
    // R7 byte align, upper shift bits ignored
    send(2'd3, 32'hA1B2C3D4, 32'h11223344, 32'd0, 1'b0, 5'd1, "R7 byte 1");
    send(2'd3, 32'hA1B2C3D4, 32'h11223344, 32'd0, 1'b0, 5'd3, "R7 byte 3");
    send(2'd3, 32'hA1B2C3D4, 32'h11223344, 32'd0, 1'b0, 5'b11110, "R7 high bits ignored");
    // R9 round and acc do not leak into other opcodes
    send(2'd2, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'hFFFFFFFF, 1'b1, 5'd4, "R9 align ignores acc/round");
    send(2'd0, 32'h00000010, 32'h00000001, 32'd100, 1'b1, 5'd9, "R9 sad ignores round");
    // gap then item
    repeat (2) @(negedge clk);
    send(2'd1, 32'h80808080, 32'h7F7F7F7F, 32'd0, 1'b1, 5'd0, "R4 after gap");

    repeat (3) @(negedge clk);
    // R8 hold while idle
    repeat (4) @(negedge clk);
    chk("R8 idle valid", {31'b0, out_valid}, 32'd0);
    chk("R8 hold", out_result, last_exp);
    chk("R2 all drained", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule